// File: doc/BRIEF.md
# Block Hamming Check-Code Engine for Flash Pages

The engine sits on the byte stream between a flash controller and the flash device. For every 512-byte block it folds each transferred byte into a 24-bit Hamming check code. On a write, the finished code goes out so that the controller can place it in the spare area behind the page data. On a read, the controller supplies the code fetched from the spare area. The engine XORs it with the freshly computed code. It then classifies the difference as a clean block, a correctable single data-bit error with its byte and bit position, a single flipped bit inside the stored code, or an uncorrectable error.

An access arms the engine only when its first byte is flagged as starting at a 512-byte-aligned address. A page holds up to four blocks. Blocks close one after another every 512 bytes, or earlier when a byte carries the last flag. A per-block status register bank keeps the read verdict of every block of the current page. Correcting the data in a buffer is left to the user.

Top module: `ecc512_engine`

## Requirements
- R1: The code of a block is a function of byte address a (0..511 within the block) and bit index b (0..7) of every set data bit. Code bit 2k (k = 0..8) is the parity of the set bits whose address has bit k clear, and bit 2k+1 is the parity of those whose address has bit k set. Bit 18+2j (j = 0..2) is the parity of the set bits whose index has bit j clear, and bit 19+2j is the parity of those whose index has bit j set. The code is shown on res_code with every result, so an all-zero block gives code 0.
- R2: res_valid is high for exactly one cycle, in the cycle after the byte that closes a block, and res_block then gives the block index (0..3) within the page.
- R3: A start byte (in_valid and in_start) with in_aligned low is ignored. The engine goes idle (busy low) and produces no result until the next aligned start.
- R4: A byte with in_last closes the current block at whatever length it has reached, and the engine is idle in the next cycle.
- R5: Without in_last, a block closes after its 512th byte and the next byte starts the following block. After the fourth block closes, the engine is idle.
- R6: On a read (in_read high at the start byte), a zero syndrome (stored code XOR computed code) gives res_status 0.
- R7: On a read, a syndrome in which all 12 bit pairs (2i, 2i+1) differ gives res_status 1. res_byte is then the odd line bits (code bits 1,3,..,17) and res_bit is the odd column bits (19,21,23), which name the flipped data bit.
- R8: On a read, a syndrome with exactly one set bit gives res_status 2 (error inside the stored code).
- R9: On a read, any other nonzero syndrome, such as two flipped data bits, gives res_status 3 (uncorrectable).
- R10: blk_status holds the verdict of block i in bits [2i+1:2i]. All fields clear to 0 on an aligned start, each field is written when its block closes, and fields hold otherwise.
- R11: On a write (in_read low at the start byte), in_stored_code is ignored and every block's status is 0.
- R12: After reset, res_valid and busy are low and blk_status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data byte is present this cycle |
| in_start | input | 1 | This byte is the first of an access |
| in_last | input | 1 | This byte is the last of an access |
| in_aligned | input | 1 | The access starts at a 512-byte-aligned address (read with in_start) |
| in_read | input | 1 | Access is a read (1) or a write (0), read with in_start |
| in_data | input | 8 | Data byte |
| in_stored_code | input | 24 | Code from the spare area, read with the closing byte of a block |
| busy | output | 1 | Engine armed inside a page |
| res_valid | output | 1 | One-cycle result strobe |
| res_block | output | 2 | Index of the reported block within the page |
| res_status | output | 2 | 0 clean, 1 correctable, 2 code-bit error, 3 uncorrectable |
| res_code | output | 24 | Code computed over the block |
| res_byte | output | 9 | Byte position of a correctable error |
| res_bit | output | 3 | Bit position of a correctable error |
| blk_status | output | 8 | Per-block verdicts of the current page |

## Verification
Each result register takes its value on the clock edge that accepts a block's closing byte. The bench drives a byte on a falling edge and reads res_valid, res_status, res_code and the position fields on the following falling edge, one clock after the closing byte. On that same falling edge it drives the next byte, and one edge later it confirms that the strobe has dropped. busy and blk_status are read one cycle after the closing or start byte that changes them. The unaligned case is watched on every cycle of the stream, so a stray strobe is caught at once.

// File: rtl/ecc512_pkg.sv
package ecc512_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int ADDR_W     = 9;
    localparam int BLOCK_BYTES = 1 << ADDR_W;
    localparam int LINE_W     = 2 * ADDR_W;
    localparam int COL_W      = 2 * BIT_IDX_W;
    localparam int CODE_W     = LINE_W + COL_W;
    localparam int PAIRS      = ADDR_W + BIT_IDX_W;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXABLE  = 2'd1,
        ST_CODE_ERR = 2'd2,
        ST_UNCORR   = 2'd3
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e             status;
        logic [ADDR_W-1:0]       byte_idx;
        logic [BIT_IDX_W-1:0]    bit_idx;
    } ecc_verdict_t;

    // Contribution of one byte at a given position to the block code.
    function automatic logic [CODE_W-1:0] byte_contrib(
        input logic [ADDR_W-1:0] addr,
        input logic [BYTE_W-1:0] data
    );
        logic [CODE_W-1:0] c;
        logic p, ev, od;
        c = '0;
        p = ^data;
        for (int k = 0; k < ADDR_W; k++) begin
            c[2*k]   = p & ~addr[k];
            c[2*k+1] = p & addr[k];
        end
        for (int j = 0; j < BIT_IDX_W; j++) begin
            ev = 1'b0;
            od = 1'b0;
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> j) & 1) == 1) od = od ^ data[b];
                else                     ev = ev ^ data[b];
            end
            c[LINE_W+2*j]   = ev;
            c[LINE_W+2*j+1] = od;
        end
        return c;
    endfunction

    // Decode a syndrome into a verdict.
    function automatic ecc_verdict_t classify(input logic [CODE_W-1:0] syn);
        ecc_verdict_t v;
        logic all_split;
        v.status   = ST_CLEAN;
        v.byte_idx = '0;
        v.bit_idx  = '0;
        all_split  = 1'b1;
        for (int i = 0; i < PAIRS; i++)
            all_split = all_split & (syn[2*i] ^ syn[2*i+1]);
        if (syn != '0) begin
            if (all_split) begin
                v.status = ST_FIXABLE;
                for (int k = 0; k < ADDR_W; k++)
                    v.byte_idx[k] = syn[2*k+1];
                for (int j = 0; j < BIT_IDX_W; j++)
                    v.bit_idx[j] = syn[LINE_W+2*j+1];
            end else if ($countones(syn) == 1) begin
                v.status = ST_CODE_ERR;
            end else begin
                v.status = ST_UNCORR;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/ecc512_accum.sv
module ecc512_accum
    import ecc512_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 first,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    data,
    output logic [CODE_W-1:0]    code_next
);

    logic [CODE_W-1:0] acc_q;
    logic [CODE_W-1:0] contrib;

    assign contrib   = byte_contrib(addr, data);
    assign code_next = (first ? '0 : acc_q) ^ contrib;

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (take) acc_q <= code_next;
    end

endmodule

// File: rtl/ecc512_classify.sv
module ecc512_classify
    import ecc512_pkg::*;
(
    input  logic [CODE_W-1:0] computed,
    input  logic [CODE_W-1:0] stored,
    output ecc_verdict_t      verdict
);

    logic [CODE_W-1:0] syndrome;

    assign syndrome = computed ^ stored;
    assign verdict  = classify(syndrome);

endmodule

// File: rtl/ecc512_status_bank.sv
module ecc512_status_bank
    import ecc512_pkg::*;
#(
    parameter int BLOCKS = 4,
    localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr,
    input  logic [BLK_W-1:0]      idx,
    input  ecc_status_e           status,
    output logic [2*BLOCKS-1:0]   flat
);

    for (genvar g = 0; g < BLOCKS; g++) begin : g_slot
        ecc_status_e slot_q;
        always_ff @(posedge clk) begin
            if (rst)                                slot_q <= ST_CLEAN;
            else if (wr && (idx == BLK_W'(g)))      slot_q <= status;
            else if (clr)                           slot_q <= ST_CLEAN;
        end
        assign flat[2*g +: 2] = slot_q;
    end

    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr && !clr) |=> $stable(flat));

endmodule

// File: rtl/ecc512_engine.sv
module ecc512_engine
    import ecc512_pkg::*;
#(
    parameter int BLOCKS = 4,
    localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_start,
    input  logic                  in_last,
    input  logic                  in_aligned,
    input  logic                  in_read,
    input  logic [BYTE_W-1:0]     in_data,
    input  logic [CODE_W-1:0]     in_stored_code,
    output logic                  busy,
    output logic                  res_valid,
    output logic [BLK_W-1:0]      res_block,
    output logic [1:0]            res_status,
    output logic [CODE_W-1:0]     res_code,
    output logic [ADDR_W-1:0]     res_byte,
    output logic [BIT_IDX_W-1:0]  res_bit,
    output logic [2*BLOCKS-1:0]   blk_status
);

    logic                  busy_q, rd_q;
    logic [ADDR_W-1:0]     cnt_q;
    logic [BLK_W-1:0]      blk_q;

    logic                  start_evt, abort_evt, take, close, last_blk, rd_eff;
    logic [ADDR_W-1:0]     addr;
    logic [BLK_W-1:0]      blk;
    logic [CODE_W-1:0]     code_next;
    ecc_verdict_t          verdict;
    ecc_status_e           blk_verdict;

    // Control: arm on aligned start, drop on unaligned start.
    assign start_evt = in_valid && in_start && in_aligned;
    assign abort_evt = in_valid && in_start && !in_aligned;
    assign take      = start_evt || (in_valid && busy_q && !in_start);
    assign addr      = start_evt ? '0 : cnt_q;
    assign blk       = start_evt ? '0 : blk_q;
    assign rd_eff    = start_evt ? in_read : rd_q;
    assign close     = take && ((&addr) || in_last);
    assign last_blk  = (blk == BLK_W'(BLOCKS-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            cnt_q  <= '0;
            blk_q  <= '0;
        end else if (abort_evt) begin
            busy_q <= 1'b0;
        end else if (take) begin
            busy_q <= !(close && (in_last || last_blk));
            cnt_q  <= close ? '0 : addr + 1'b1;
            blk_q  <= close ? blk + 1'b1 : blk;
            rd_q   <= rd_eff;
        end
    end

    ecc512_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .first     (addr == '0),
        .addr      (addr),
        .data      (in_data),
        .code_next (code_next)
    );

    ecc512_classify u_classify (
        .computed (code_next),
        .stored   (in_stored_code),
        .verdict  (verdict)
    );

    assign blk_verdict = rd_eff ? verdict.status : ST_CLEAN;

    // Result registers.
    logic                  res_valid_q;
    logic [BLK_W-1:0]      res_block_q;
    ecc_status_e           res_status_q;
    logic [CODE_W-1:0]     res_code_q;
    logic [ADDR_W-1:0]     res_byte_q;
    logic [BIT_IDX_W-1:0]  res_bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_q  <= 1'b0;
            res_block_q  <= '0;
            res_status_q <= ST_CLEAN;
            res_code_q   <= '0;
            res_byte_q   <= '0;
            res_bit_q    <= '0;
        end else begin
            res_valid_q <= close;
            if (close) begin
                res_block_q  <= blk;
                res_status_q <= blk_verdict;
                res_code_q   <= code_next;
                res_byte_q   <= rd_eff ? verdict.byte_idx : '0;
                res_bit_q    <= rd_eff ? verdict.bit_idx  : '0;
            end
        end
    end

    ecc512_status_bank #(.BLOCKS(BLOCKS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_evt),
        .wr     (close),
        .idx    (blk),
        .status (blk_verdict),
        .flat   (blk_status)
    );

    assign busy       = busy_q;
    assign res_valid  = res_valid_q;
    assign res_block  = res_block_q;
    assign res_status = res_status_q;
    assign res_code   = res_code_q;
    assign res_byte   = res_byte_q;
    assign res_bit    = res_bit_q;

    assert_strobe_after_close_R2: assert property (@(posedge clk) disable iff (rst)
        close |=> res_valid);

    assert_strobe_needs_byte_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(take));

    assert_unaligned_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && !in_aligned) |=> (!busy && !res_valid));

    assert_last_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> !busy);

    assert_write_clean_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !rd_q) |-> (res_status == ST_CLEAN));

endmodule

// File: tb/test_ecc512_engine.sv
`timescale 1ns/1ps
module test_ecc512_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_start, in_last, in_aligned, in_read;
    logic [7:0]  in_data;
    logic [23:0] in_stored_code;
    logic        busy, res_valid;
    logic [1:0]  res_block, res_status;
    logic [23:0] res_code;
    logic [8:0]  res_byte;
    logic [2:0]  res_bit;
    logic [7:0]  blk_status;

    always #2.5 clk = ~clk;

    ecc512_engine i_ecc512_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_aligned(in_aligned), .in_read(in_read),
        .in_data(in_data), .in_stored_code(in_stored_code), .busy(busy),
        .res_valid(res_valid), .res_block(res_block), .res_status(res_status),
        .res_code(res_code), .res_byte(res_byte), .res_bit(res_bit),
        .blk_status(blk_status)
    );

    int vectors = 0;
    int fails   = 0;

    logic [7:0]  clean [2048];
    logic [7:0]  tx    [2048];
    logic [23:0] sc    [4];
    int          exp_st   [4];
    int          exp_byte [4];
    int          exp_bit  [4];
    string       exp_req  [4];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Code built bit by bit from the layout stated in R1.
    function automatic logic [23:0] ref_code(input bit use_tx, input int base, input int len);
        logic [23:0] c = '0;
        logic [7:0]  d;
        for (int a = 0; a < len; a++) begin
            d = use_tx ? tx[base+a] : clean[base+a];
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    for (int k = 0; k < 9; k++) c[2*k + ((a >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 3; j++) c[18 + 2*j + ((b >> j) & 1)] ^= 1'b1;
                end
            end
        end
        return c;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 2048; i++) begin
            clean[i] = 8'((i * 37) ^ (seed * 91) ^ (i >> 3));
            tx[i]    = clean[i];
        end
        for (int b = 0; b < 4; b++) begin
            exp_st[b] = 0; exp_byte[b] = 0; exp_bit[b] = 0; exp_req[b] = "R6";
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; in_start = 0; in_last = 0; in_aligned = 0; in_read = 0;
        in_data = '0; in_stored_code = '0;
    endtask

    task automatic check_result(input bit pend, input int blk, input int len, input string tag);
        if (pend) begin
            chk("R2", {tag, " res_valid"}, res_valid, 1);
            chk("R2", {tag, " res_block"}, res_block, blk);
            chk("R1", {tag, " res_code"}, res_code, ref_code(1, blk * 512, len));
            chk(exp_req[blk], {tag, " res_status"}, res_status, exp_st[blk]);
            if (exp_st[blk] == 1) begin
                chk("R7", {tag, " res_byte"}, res_byte, exp_byte[blk]);
                chk("R7", {tag, " res_bit"}, res_bit, exp_bit[blk]);
            end
        end else if (res_valid) begin
            chk("R3", {tag, " stray res_valid"}, res_valid, 0);
        end
    endtask

    task automatic run_stream(input int n, input bit rd, input bit aligned,
                              input bit use_last, input string tag);
        bit pend = 0;
        int pblk = 0;
        int plen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_result(pend, pblk, plen, tag);
            if (i == 600) chk("R5", {tag, " busy mid page"}, busy, 1);
            in_valid = 1; in_data = tx[i]; in_start = (i == 0);
            in_aligned = aligned; in_read = rd;
            in_last = use_last && (i == n - 1);
            in_stored_code = sc[i / 512];
            pblk = i / 512;
            plen = i - pblk * 512 + 1;
            pend = aligned && ((i % 512 == 511) || (use_last && i == n - 1));
        end
        @(negedge clk);
        check_result(pend, pblk, plen, tag);
        idle_inputs();
        @(negedge clk);
        chk("R2", {tag, " strobe one cycle"}, res_valid, 0);
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R12", "reset res_valid", res_valid, 0);
        chk("R12", "reset busy", busy, 0);
        chk("R12", "reset blk_status", blk_status, 0);
    endtask

    task automatic t_write();
        fill(1);
        for (int b = 0; b < 4; b++) begin sc[b] = 24'hABCDEF; exp_req[b] = "R11"; end
        run_stream(512, 0, 1, 1, "write");
        chk("R4", "write busy after last", busy, 0);
        chk("R11", "write blk_status", blk_status, 0);
    endtask

    task automatic t_zero();
        for (int i = 0; i < 2048; i++) begin clean[i] = '0; tx[i] = '0; end
        for (int b = 0; b < 4; b++) begin sc[b] = 24'h123456; exp_st[b] = 0; exp_req[b] = "R11"; end
        run_stream(512, 0, 1, 1, "zero");
    endtask

    task automatic t_read_clean();
        fill(2);
        sc[0] = ref_code(0, 0, 512);
        run_stream(512, 1, 1, 1, "read clean");
        chk("R10", "clean blk_status", blk_status, 0);
    endtask

    task automatic t_single();
        fill(3);
        sc[0] = ref_code(0, 0, 512);
        tx[300][5] = ~tx[300][5];
        exp_st[0] = 1; exp_byte[0] = 300; exp_bit[0] = 5; exp_req[0] = "R7";
        run_stream(512, 1, 1, 1, "single");
        chk("R10", "single blk_status", blk_status, 8'h01);
    endtask

    task automatic t_double();
        fill(4);
        sc[0] = ref_code(0, 0, 512);
        tx[10][0]  = ~tx[10][0];
        tx[400][7] = ~tx[400][7];
        exp_st[0] = 3; exp_req[0] = "R9";
        run_stream(512, 1, 1, 1, "double");
        chk("R10", "double blk_status", blk_status, 8'h03);
    endtask

    task automatic t_code_err();
        fill(5);
        sc[0] = ref_code(0, 0, 512) ^ (24'h1 << 13);
        exp_st[0] = 2; exp_req[0] = "R8";
        run_stream(512, 1, 1, 1, "code bit");
        chk("R10", "code blk_status", blk_status, 8'h02);
    endtask

    task automatic t_unaligned();
        fill(6);
        sc[0] = 24'hFFFFFF;
        run_stream(20, 1, 0, 1, "unaligned");
        chk("R3", "unaligned busy", busy, 0);
        chk("R3", "unaligned blk_status kept", blk_status, 8'h02);
    endtask

    task automatic t_short();
        fill(7);
        sc[0] = ref_code(0, 0, 37);
        run_stream(37, 1, 1, 1, "short");
        chk("R4", "short busy", busy, 0);
        chk("R10", "short blk_status", blk_status, 0);
    endtask

    task automatic t_page();
        fill(8);
        for (int b = 0; b < 4; b++) sc[b] = ref_code(0, b * 512, 512);
        tx[512 + 77][2] = ~tx[512 + 77][2];
        exp_st[1] = 1; exp_byte[1] = 77; exp_bit[1] = 2; exp_req[1] = "R7";
        tx[1024 + 5][1] = ~tx[1024 + 5][1];
        tx[1024 + 6][1] = ~tx[1024 + 6][1];
        exp_st[2] = 3; exp_req[2] = "R9";
        sc[3] = sc[3] ^ (24'h1 << 22);
        exp_st[3] = 2; exp_req[3] = "R8";
        run_stream(2048, 1, 1, 0, "page");
        chk("R5", "page busy after fourth block", busy, 0);
        chk("R10", "page blk_status", blk_status, 8'b10_11_01_00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_zero();
        t_read_clean();
        t_single();
        t_double();
        t_code_err();
        t_unaligned();
        t_short();
        t_page();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule